// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block carries out the memory side of subroutine linkage for a small 32-bit processor. A one-cycle start pulse picks one of four operations: an absolute call, a register-indirect call, a return, or a trap entry. The block then steps through the stack frame over a single word-wide memory port and reports the new frame pointer, stack pointer and program counter with a one-cycle done pulse. The core writes these values back into its registers.

A call or trap builds a three-word frame below the incoming stack pointer. The highest word is a static-chain slot that is reserved but never written. Below it sits the return address, and below that the caller's frame pointer. Both pointers then point at the lowest word. A return unwinds from the frame pointer and not from the stack pointer, so a callee can move its stack pointer freely without upsetting the unwind. Every memory access holds its request until the memory acknowledges it, so memory latency can vary.

Top module: `frame_seq`

## Requirements
- R1: After reset, done, busy and mem_req are low, and fp_out, sp_out and pc_out are zero.
- R2: During a call or trap with incoming stack pointer S, the word at S-4 (the static-chain slot) is never written. The only words written are at S-8 and S-12.
- R3: A call or trap makes exactly two write accesses. The first stores the return address at S-8 and the second stores the incoming frame pointer at S-12.
- R4: When a call or trap completes, fp_out and sp_out both equal S-12, and pc_out equals the target input.
- R5: The return address is instr_addr+6 for op 2'b00 (absolute call) and instr_addr+2 for op 2'b01 (register-indirect call).
- R6: A return (op 2'b10) with incoming frame pointer F makes exactly two reads: first at F, then at F+4. fp_out takes the word read at F, and pc_out takes the word read at F+4.
- R7: After a return, sp_out equals F+12, so the static-chain slot is skipped.
- R8: A trap entry (op 2'b11) stores instr_addr+6 as the return address and sets pc_out to the handler address given on target.
- R9: Once mem_req rises, mem_req, mem_we, mem_addr and mem_wdata hold steady until the cycle in which mem_ack is high.
- R10: done is high for exactly one cycle per accepted operation, and busy is low while done is high.
- R11: A start pulse that arrives while busy is high is ignored. It causes no extra memory access, no extra done pulse, and no change to the result of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle operation request, taken only when idle |
| op | input | 2 | 00 absolute call, 01 register call, 10 return, 11 trap |
| instr_addr | input | W | Address of the call or trap instruction |
| target | input | W | Call target or trap handler address |
| fp_in | input | W | Current frame pointer |
| sp_in | input | W | Current stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fp_out | output | W | New frame pointer, valid with done |
| sp_out | output | W | New stack pointer, valid with done |
| pc_out | output | W | New program counter, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | W | Byte address of the word |
| mem_wdata | output | W | Write data |
| mem_ack | input | 1 | Access accepted; read data valid in the same cycle |
| mem_rdata | input | W | Read data |

## Verification
The hardest case to reach from the ports is a second start pulse that lands while the memory is stalling one of the frame accesses. Only then could a faulty sequencer relatch its operands or restart the frame halfway through. The bench's memory model adds a random zero to three cycle delay before each acknowledge. Some runs inject a stray start, with a different operation and different operands, two cycles after the real one. After each operation the bench checks the access log, the results and a quiet interval.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] instr_addr,
  input  logic [W-1:0] target,
  input  logic [W-1:0] fp_in,
  input  logic [W-1:0] sp_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] fp_out,
  output logic [W-1:0] sp_out,
  output logic [W-1:0] pc_out,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic         mem_ack,
  input  logic [W-1:0] mem_rdata
);
  localparam logic [W-1:0] STEP      = W'(W / 8);
  localparam logic [W-1:0] SHORT_LEN = W'(2);
  localparam logic [W-1:0] LONG_LEN  = W'(6);

  typedef enum logic [2:0] {S_IDLE, S_W_RA, S_W_FP, S_R_FP, S_R_RA} state_t;

  state_t       state;
  logic [1:0]   op_q;
  logic [W-1:0] ra_q, tgt_q, fp_q, sp_q, link_fp_q;

  assign busy    = (state != S_IDLE);
  assign mem_req = busy;
  assign mem_we  = (state == S_W_RA) || (state == S_W_FP);

  always_comb begin
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_W_RA: begin mem_addr = sp_q - 2*STEP; mem_wdata = ra_q; end
      S_W_FP: begin mem_addr = sp_q - 3*STEP; mem_wdata = fp_q; end
      S_R_FP: mem_addr = fp_q;
      S_R_RA: mem_addr = fp_q + STEP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= '0;
      ra_q      <= '0;
      tgt_q     <= '0;
      fp_q      <= '0;
      sp_q      <= '0;
      link_fp_q <= '0;
      fp_out    <= '0;
      sp_out    <= '0;
      pc_out    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          op_q  <= op;
          tgt_q <= target;
          fp_q  <= fp_in;
          sp_q  <= sp_in;
          ra_q  <= instr_addr + ((op == 2'b01) ? SHORT_LEN : LONG_LEN);
          state <= (op == 2'b10) ? S_R_FP : S_W_RA;
        end
        S_W_RA: if (mem_ack) state <= S_W_FP;
        S_W_FP: if (mem_ack) begin
          fp_out <= sp_q - 3*STEP;
          sp_out <= sp_q - 3*STEP;
          pc_out <= tgt_q;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        S_R_FP: if (mem_ack) begin
          link_fp_q <= mem_rdata;
          state     <= S_R_RA;
        end
        S_R_RA: if (mem_ack) begin
          fp_out <= link_fp_q;
          pc_out <= mem_rdata;
          sp_out <= fp_q + 3*STEP;
          done   <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module frame_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic         done,
  input logic         mem_req,
  input logic         mem_we,
  input logic         mem_ack,
  input logic [W-1:0] mem_addr,
  input logic [W-1:0] mem_wdata,
  input logic [W-1:0] fp_out,
  input logic [W-1:0] sp_out,
  input logic [1:0]   op_q
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

  // R4
  call_ptrs_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (op_q != 2'b10) |-> fp_out == sp_out);

  // R3
  write_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we && mem_ack && (op_q != 2'b10) |=> !done || $past(mem_addr) == sp_out);
endmodule

bind frame_seq frame_seq_chk #(.W(W)) i_frame_seq_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .fp_out(fp_out), .sp_out(sp_out), .op_q(op_q)
);

// File: tb/test_frame_seq.sv
module test_frame_seq;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   op = '0;
  logic [W-1:0] instr_addr = '0, target = '0, fp_in = '0, sp_in = '0;
  logic         busy, done, mem_req, mem_we;
  logic [W-1:0] fp_out, sp_out, pc_out, mem_addr, mem_wdata;
  logic         mem_ack = 1'b0;
  logic [W-1:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;

  logic [W-1:0] mem [logic [W-1:0]];
  logic [W-1:0] log_addr [0:15];
  logic         log_we   [0:15];
  logic [W-1:0] log_data [0:15];
  int           log_n = 0;

  frame_seq #(.W(W)) i_frame_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .instr_addr(instr_addr), .target(target), .fp_in(fp_in), .sp_in(sp_in),
    .busy(busy), .done(done), .fp_out(fp_out), .sp_out(sp_out), .pc_out(pc_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  always #4 clk = ~clk;

  function automatic logic [W-1:0] rd(input logic [W-1:0] a);
    return mem.exists(a) ? mem[a] : '0;
  endfunction

  function automatic logic [W-1:0] exp_ra(input logic [1:0] o, input logic [W-1:0] ia);
    return (o == 2'b01) ? ia + 2 : ia + 6;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int wait_c = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        if (wait_c > 0) wait_c--;
        else begin
          mem_ack = 1'b1;
          if (log_n < 16) begin
            log_addr[log_n] = mem_addr;
            log_we[log_n]   = mem_we;
            log_data[log_n] = mem_wdata;
          end
          log_n++;
          if (mem_we) mem[mem_addr] = mem_wdata;
          else mem_rdata = rd(mem_addr);
          wait_c = int'($urandom % 4);
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic run_op(input logic [1:0] o, input logic [W-1:0] ia, input logic [W-1:0] tg,
                        input logic [W-1:0] fp, input logic [W-1:0] sp, input bit stray);
    logic [W-1:0] e_fp, e_sp, e_pc, w0, w1, sentinel;
    int n0, cyc;
    bit got;
    sentinel = 32'h5A5A_0000 ^ sp;
    if (o == 2'b10) begin
      w0 = $urandom; w1 = $urandom;
      mem[fp] = w0; mem[fp + 4] = w1;
      e_fp = w0; e_pc = w1; e_sp = fp + 12;
    end else begin
      mem[sp - 4] = sentinel;
      e_fp = sp - 12; e_sp = sp - 12; e_pc = tg;
    end
    log_n = 0;
    @(negedge clk);
    start = 1'b1; op = o; instr_addr = ia; target = tg; fp_in = fp; sp_in = sp;
    @(negedge clk);
    start = 1'b0; op = ~o; instr_addr = $urandom; target = $urandom; fp_in = $urandom; sp_in = $urandom;
    if (stray) begin
      @(negedge clk);
      start = 1'b1; op = o ^ 2'b10;
      @(negedge clk);
      start = 1'b0;
    end
    got = 1'b0;
    for (cyc = 0; cyc < 200 && !got; cyc++) begin
      if (done) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, "R10 done seen", {31'b0, got}, 1);
    chk(!busy, "R10 busy low with done", {31'b0, busy}, 0);
    chk(fp_out == e_fp, (o == 2'b10) ? "R6 fp_out" : "R4 fp_out", fp_out, e_fp);
    chk(sp_out == e_sp, (o == 2'b10) ? "R7 sp_out" : "R4 sp_out", sp_out, e_sp);
    chk(pc_out == e_pc, (o == 2'b10) ? "R6 pc_out" : ((o == 2'b11) ? "R8 pc_out" : "R4 pc_out"), pc_out, e_pc);
    chk(log_n == 2, "R3/R6 access count", log_n, 2);
    if (o == 2'b10) begin
      chk(!log_we[0] && log_addr[0] == fp, "R6 first read", log_addr[0], fp);
      chk(!log_we[1] && log_addr[1] == fp + 4, "R6 second read", log_addr[1], fp + 4);
    end else begin
      chk(log_we[0] && log_addr[0] == sp - 8, "R3 first write addr", log_addr[0], sp - 8);
      chk(log_data[0] == exp_ra(o, ia), (o == 2'b11) ? "R8 return address" : "R5 return address",
          log_data[0], exp_ra(o, ia));
      chk(log_we[1] && log_addr[1] == sp - 12, "R3 second write addr", log_addr[1], sp - 12);
      chk(log_data[1] == fp, "R3 saved frame pointer", log_data[1], fp);
      chk(rd(sp - 4) == sentinel, "R2 static-chain slot untouched", rd(sp - 4), sentinel);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", {31'b0, done}, 0);
    n0 = log_n;
    got = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk(!got && log_n == n0 && !busy, stray ? "R11 stray start ignored" : "R10 quiet after done",
        log_n, n0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!done && !busy && !mem_req, "R1 control low in reset", {29'b0, done, busy, mem_req}, 0);
    chk(fp_out == 0 && sp_out == 0 && pc_out == 0, "R1 outputs zero", fp_out | sp_out | pc_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !busy && !mem_req, "R1 idle after reset", {29'b0, done, busy, mem_req}, 0);

    run_op(2'b00, 32'h0000_1000, 32'h0000_2000, 32'h0000_8000, 32'h0000_7FF0, 1'b0);
    run_op(2'b01, 32'h0000_1010, 32'h0000_3000, 32'h0000_7FE4, 32'h0000_7FE4, 1'b0);
    run_op(2'b11, 32'h0000_1020, 32'hE000_0100, 32'h0000_7FD8, 32'h0000_7FD0, 1'b0);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_7FC4, 32'h0000_7F00, 1'b0);
    run_op(2'b00, 32'hFFFF_FFFC, 32'h0, 32'h0, 32'h0000_0008, 1'b0);
    run_op(2'b10, 32'h0, 32'h0, 32'hFFFF_FFF8, 32'h0, 1'b0);
    run_op(2'b01, 32'h0000_4000, 32'h0000_5000, 32'h0000_6000, 32'h0000_6100, 1'b1);
    run_op(2'b10, 32'h0, 32'h0, 32'h0000_6200, 32'h0000_6000, 1'b1);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] o;
      logic [W-1:0] sp, fp;
      o  = 2'($urandom);
      sp = {4'h1, 18'($urandom), 10'h0} + (i * 64);
      fp = {4'h2, 18'($urandom), 10'h0} + (i * 64);
      run_op(o, $urandom & 32'hFFFF_FFFE, $urandom, fp, sp, (i % 3) == 0);
    end
    finish_run();
  end
endmodule